// File: doc/BRIEF.md
# Shared-Pool Packet Header Queues

This block holds packet headers for two queues that draw their storage from one pool of header buffers. Each header carries a destination instruction number, a tag made of a code-block context and an iteration count, and a pointer to the first token of the packet's data. The match queue takes headers from several processor producers and is drained by the matching stage. The fetch queue is filled by the matching stage and drained by the fetch stage.

To enqueue, a producer takes a free buffer index, the header is written into that buffer, and the index joins the tail of the target queue. All three steps happen on one clock edge. A consumer sees the header at the head of its queue. When it pops, it takes its copy of the header in that cycle, and the index goes back to the free list on the same edge. Queues hold only indices. The header RAM is written once per acquire.

The free list accepts two releases per cycle, one from each consumer, and hands out one index per cycle. When the free list is empty, both producer sides stall.

Top module: `hdrq_pool`

## Requirements
- R1: After reset all NBUF buffers are free, `mq_valid_o` and `fq_valid_o` are low, and `fq_ready_o` is high.
- R2: A header from a match producer granted in a cycle (`mq_gnt_o` bit high) is shown on `mq_hdr_o` with all fields unchanged, with `mq_valid_o` high from the next cycle. Headers leave in the order in which they were granted.
- R3: A header offered with `fq_push_i` while `fq_ready_o` is high is accepted in that cycle. Such headers appear on `fq_hdr_o` in arrival order, unchanged, with `fq_valid_o` high from the next cycle.
- R4: `mq_gnt_o` has at most one bit set and only for a requesting producer. The search for a requester starts at index 0 after reset. After a grant to producer i it starts at (i+1) mod NPROD.
- R5: When every buffer is held by a queue, `mq_gnt_o` is zero and `fq_ready_o` is low.
- R6: In any cycle with `fq_push_i` high, `mq_gnt_o` is zero. The single acquire of that cycle goes to the fetch-queue producer.
- R7: Acquire and up to two releases in the same cycle are all honoured. The number of free buffers always equals NBUF minus the headers held in both queues, so `fq_ready_o` is high exactly when fewer than NBUF headers are queued.
- R8: A pop while the queue's valid is low has no effect on that queue or on the pool.
- R9: Each queued header is read back intact even with all NBUF buffers in use. No buffer index is in both queues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mq_req_i | input | NPROD | Match-queue enqueue request, one bit per producer |
| mq_hdr_i | input | NPROD*HDR_W | Header from each producer, producer p in slice p |
| mq_gnt_o | output | NPROD | One-hot acceptance of a producer's header this cycle |
| mq_valid_o | output | 1 | Match queue not empty |
| mq_hdr_o | output | HDR_W | Header at the match-queue head |
| mq_pop_i | input | 1 | Matching stage takes the head header |
| fq_push_i | input | 1 | Matching stage offers a header to the fetch queue |
| fq_hdr_i | input | HDR_W | Header offered to the fetch queue |
| fq_ready_o | output | 1 | A free buffer exists, so a fetch push is accepted |
| fq_valid_o | output | 1 | Fetch queue not empty |
| fq_hdr_o | output | HDR_W | Header at the fetch-queue head |
| fq_pop_i | input | 1 | Fetch stage takes the head header |

## Verification
The bench keeps its own count of queued headers and its own round-robin pointer. It drives every request mask repeatedly, with and without simultaneous pops, so a pointer that fails to advance past the last winner, or that always restarts at zero, shows up as a wrong grant.

The pool is filled to the last buffer and then cycled with a release and an acquire in the same cycle. A free list that drops or doubles an index shows up as a wrong ready or a stall count off by one. A duplicated index shows up as a corrupted header on readback. Pops on empty queues and fetch pushes that collide with processor requests are also driven. A design that moved a pointer on an empty pop, or granted a processor in the same cycle as a fetch push, would show up as a wrong stall count or a lost header.

// File: rtl/hdrq_pkg.sv
`timescale 1ns/1ps
package hdrq_pkg;
   // header field widths
   parameter int INSTR_W = 10;
   parameter int BLK_W   = 6;
   parameter int ITER_W  = 8;
   parameter int PTR_W   = 12;
   localparam int HDR_W  = INSTR_W + BLK_W + ITER_W + PTR_W;

   typedef struct packed {
      logic [INSTR_W-1:0] instr;
      logic [BLK_W-1:0]   blk;
      logic [ITER_W-1:0]  iter;
      logic [PTR_W-1:0]   tok_ptr;
   } hdr_t;
endpackage

// File: rtl/hdrq_ring.sv
`timescale 1ns/1ps
// Circular index store: two write ports (a before b), one read port.
module hdrq_ring #(
   parameter int DEPTH     = 32,
   parameter int W         = 5,
   parameter bit INIT_FULL = 1'b0,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_a_i,
   input  logic [W-1:0]  data_a_i,
   input  logic          push_b_i,
   input  logic [W-1:0]  data_b_i,
   input  logic          pop_i,
   output logic [W-1:0]  head_o,
   output logic          empty_o,
   output logic [CW-1:0] count_o
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rp, wp, wp_b;
   logic [CW-1:0] cnt;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hdrq_ring: DEPTH must be a power of two >= 2");
   end
   if (INIT_FULL && (W < AW)) begin : g_bad_width
      $error("hdrq_ring: W too narrow to hold initial indices");
   end

   assign wp_b    = push_a_i ? wp + AW'(1) : wp;
   assign head_o  = mem[rp];
   assign empty_o = (cnt == '0);
   assign count_o = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= INIT_FULL ? W'(i) : '0;
         end
         rp  <= '0;
         wp  <= '0;
         cnt <= INIT_FULL ? CW'(DEPTH) : '0;
      end else begin
         if (push_a_i) mem[wp]   <= data_a_i;
         if (push_b_i) mem[wp_b] <= data_b_i;
         wp  <= wp + AW'(push_a_i) + AW'(push_b_i);
         rp  <= rp + AW'(pop_i);
         cnt <= cnt + CW'(push_a_i) + CW'(push_b_i) - CW'(pop_i);
      end
   end

   // R8: reads only from a non-empty store
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
   // R7: a full store only takes a write when it is read in the same cycle
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(DEPTH)) && !pop_i |-> !(push_a_i || push_b_i));
   p_two_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_a_i && push_b_i && !pop_i) |-> (cnt <= CW'(DEPTH - 2)));
endmodule

// File: rtl/hdrq_rr_arb.sv
`timescale 1ns/1ps
// Rotating-priority arbiter, one grant per cycle when enabled.
module hdrq_rr_arb #(
   parameter int N = 4,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o
);
   logic [PW-1:0] ptr, nxt;
   logic          hit;

   if (N < 2) begin : g_bad_n
      $error("hdrq_rr_arb: N must be at least 2");
   end

   always_comb begin
      gnt_o = '0;
      hit   = 1'b0;
      nxt   = ptr;
      for (int k = 0; k < N; k++) begin
         if (!hit && en_i && req_i[(int'(ptr) + k) % N]) begin
            gnt_o[(int'(ptr) + k) % N] = 1'b1;
            hit = 1'b1;
            nxt = PW'((int'(ptr) + k + 1) % N);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else if (hit) ptr <= nxt;
   end

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));
   p_gnt_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);

   for (genvar i = 0; i < N; i++) begin : g_rot
      // R4: a winner is passed over next cycle while anyone else asks
      p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_o[i] |=> (!(en_i && |(req_i & ~(N'(1) << i))) || !gnt_o[i]));
   end
endmodule

// File: rtl/hdrq_pool.sv
`timescale 1ns/1ps
module hdrq_pool
   import hdrq_pkg::*;
#(
   parameter int NBUF  = 32,
   parameter int NPROD = 4,
   localparam int IXW  = $clog2(NBUF),
   localparam int CW   = $clog2(NBUF + 1),
   localparam int HW   = HDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPROD-1:0]   mq_req_i,
   input  logic [NPROD*HW-1:0] mq_hdr_i,
   output logic [NPROD-1:0]   mq_gnt_o,
   output logic               mq_valid_o,
   output logic [HW-1:0]      mq_hdr_o,
   input  logic               mq_pop_i,
   input  logic               fq_push_i,
   input  logic [HW-1:0]      fq_hdr_i,
   output logic               fq_ready_o,
   output logic               fq_valid_o,
   output logic [HW-1:0]      fq_hdr_o,
   input  logic               fq_pop_i
);
   if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0) begin : g_bad_nbuf
      $error("hdrq_pool: NBUF must be a power of two >= 2");
   end

   logic [IXW-1:0] free_head, mq_head, fq_head;
   logic           free_empty, mq_empty, fq_empty;
   logic [CW-1:0]  free_cnt, mq_cnt, fq_cnt;
   logic           acq_mq, acq_fq, acq, mq_pop_ok, fq_pop_ok;
   hdr_t           sel_hdr;
   hdr_t           ram [NBUF];

   // acquire side: fetch producer first, processors rotate
   assign fq_ready_o = !free_empty;
   assign acq_fq     = fq_push_i && !free_empty;

   hdrq_rr_arb #(.N(NPROD)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (!free_empty && !fq_push_i),
      .req_i (mq_req_i),
      .gnt_o (mq_gnt_o)
   );

   assign acq_mq = |mq_gnt_o;
   assign acq    = acq_mq || acq_fq;

   always_comb begin
      sel_hdr = '0;
      for (int p = 0; p < NPROD; p++) begin
         if (mq_gnt_o[p]) sel_hdr = sel_hdr | hdr_t'(mq_hdr_i[p*HW +: HW]);
      end
   end

   always_ff @(posedge clk) begin
      if (acq) ram[free_head] <= acq_fq ? hdr_t'(fq_hdr_i) : sel_hdr;
   end

   // release side
   assign mq_pop_ok = mq_pop_i && !mq_empty;
   assign fq_pop_ok = fq_pop_i && !fq_empty;

   hdrq_ring #(.DEPTH(NBUF), .W(IXW), .INIT_FULL(1'b1)) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_a_i (mq_pop_ok),
      .data_a_i (mq_head),
      .push_b_i (fq_pop_ok),
      .data_b_i (fq_head),
      .pop_i    (acq),
      .head_o   (free_head),
      .empty_o  (free_empty),
      .count_o  (free_cnt)
   );

   hdrq_ring #(.DEPTH(NBUF), .W(IXW), .INIT_FULL(1'b0)) u_mq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_a_i (acq_mq),
      .data_a_i (free_head),
      .push_b_i (1'b0),
      .data_b_i ('0),
      .pop_i    (mq_pop_ok),
      .head_o   (mq_head),
      .empty_o  (mq_empty),
      .count_o  (mq_cnt)
   );

   hdrq_ring #(.DEPTH(NBUF), .W(IXW), .INIT_FULL(1'b0)) u_fq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_a_i (acq_fq),
      .data_a_i (free_head),
      .push_b_i (1'b0),
      .data_b_i ('0),
      .pop_i    (fq_pop_ok),
      .head_o   (fq_head),
      .empty_o  (fq_empty),
      .count_o  (fq_cnt)
   );

   assign mq_valid_o = !mq_empty;
   assign mq_hdr_o   = HW'(ram[mq_head]);
   assign fq_valid_o = !fq_empty;
   assign fq_hdr_o   = HW'(ram[fq_head]);

   // R7: every index is in exactly one of the three stores
   p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(free_cnt) + 32'(mq_cnt) + 32'(fq_cnt)) == NBUF);
   // R6: fetch push blocks processor grants
   p_fetch_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fq_push_i |-> (mq_gnt_o == '0));
   // R5: empty pool grants nothing
   p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      free_empty |-> (mq_gnt_o == '0));
   // R2: a grant shows up at the consumer next cycle
   p_deliver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acq_mq |=> mq_valid_o);
   // R9: two queue heads never name the same buffer
   p_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mq_empty && !fq_empty) |-> (mq_head != fq_head));
endmodule

// File: tb/sim_hdrq_pool.sv
`timescale 1ns/1ps
module sim_hdrq_pool;
   localparam int NB = 32;
   localparam int NP = 4;
   localparam int HW = hdrq_pkg::HDR_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NP-1:0]      req = '0;
   logic [NP*HW-1:0]   mhdr = '0;
   logic [NP-1:0]      gnt;
   logic               mq_valid, mq_pop = 1'b0;
   logic [HW-1:0]      mq_hdr;
   logic               fq_push = 1'b0, fq_ready, fq_valid, fq_pop = 1'b0;
   logic [HW-1:0]      fq_hdr_in = '0, fq_hdr;

   int tests = 0, fails = 0, rr = 0, ser = 0;
   logic [HW-1:0] mq_m[$];
   logic [HW-1:0] fq_m[$];

   always #10 clk = ~clk;

   hdrq_pool #(.NBUF(NB), .NPROD(NP)) u0 (
      .clk(clk), .rst_n(rst_n),
      .mq_req_i(req), .mq_hdr_i(mhdr), .mq_gnt_o(gnt),
      .mq_valid_o(mq_valid), .mq_hdr_o(mq_hdr), .mq_pop_i(mq_pop),
      .fq_push_i(fq_push), .fq_hdr_i(fq_hdr_in), .fq_ready_o(fq_ready),
      .fq_valid_o(fq_valid), .fq_hdr_o(fq_hdr), .fq_pop_i(fq_pop)
   );

   function automatic logic [HW-1:0] hv(input int p, input int s);
      return HW'(s * 16 + p + 'h3000);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // one clock: drive at negedge, compare just after, model updates
   task automatic cyc(input logic [NP-1:0] r, input logic fp, input logic mp, input logic fpp);
      logic [NP-1:0] eg;
      int out;
      bit found;
      string tag;
      @(negedge clk);
      req = r;
      for (int p = 0; p < NP; p++) mhdr[p*HW +: HW] = hv(p, ser);
      fq_push = fp; fq_hdr_in = hv(15, ser);
      mq_pop = mp; fq_pop = fpp;
      #2;
      out = mq_m.size() + fq_m.size();
      eg = '0; found = 1'b0;
      if (!fp && out < NB) begin
         for (int k = 0; k < NP; k++) begin
            if (!found && r[(rr + k) % NP]) begin
               eg[(rr + k) % NP] = 1'b1;
               found = 1'b1;
            end
         end
      end
      tag = fp ? "R6 fetch priority" : (out >= NB ? "R5 pool empty stall" : "R4 round robin");
      chk(gnt == eg, tag, 64'(gnt), 64'(eg));
      chk(fq_ready == (out < NB), "R7 free count", 64'(fq_ready), 64'(out < NB));
      chk(mq_valid == (mq_m.size() > 0), "R2/R8 mq valid", 64'(mq_valid), 64'(mq_m.size() > 0));
      chk(fq_valid == (fq_m.size() > 0), "R3/R8 fq valid", 64'(fq_valid), 64'(fq_m.size() > 0));
      if (mp && mq_m.size() > 0) begin
         chk(mq_hdr == mq_m[0], "R2/R9 mq header", 64'(mq_hdr), 64'(mq_m[0]));
         void'(mq_m.pop_front());
      end
      if (fpp && fq_m.size() > 0) begin
         chk(fq_hdr == fq_m[0], "R3/R9 fq header", 64'(fq_hdr), 64'(fq_m[0]));
         void'(fq_m.pop_front());
      end
      for (int p = 0; p < NP; p++) begin
         if (eg[p]) begin
            mq_m.push_back(hv(p, ser));
            rr = (p + 1) % NP;
         end
      end
      if (fp && out < NB) fq_m.push_back(hv(15, ser));
      ser++;
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(20 * 20000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk(mq_valid == 1'b0, "R1 mq valid", 64'(mq_valid), 0);
      chk(fq_valid == 1'b0, "R1 fq valid", 64'(fq_valid), 0);
      chk(fq_ready == 1'b1, "R1 ready", 64'(fq_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 all producers contend; R2 order
      repeat (12) cyc(4'hF, 1'b0, 1'b0, 1'b0);
      // R2 drain, R8 pops past empty
      repeat (15) cyc('0, 1'b0, 1'b1, 1'b0);

      // R4 every request mask, with and without same-cycle release (R7)
      for (int pass = 0; pass < 2; pass++)
         for (int m = 1; m < 16; m++) cyc(NP'(m), 1'b0, 1'b0, 1'b0);
      for (int m = 1; m < 16; m++) cyc(NP'(m), 1'b0, 1'b1, 1'b0);
      repeat (40) cyc('0, 1'b0, 1'b1, 1'b0);

      // R6 fetch push collides with processors; R3 fetch order
      repeat (6) cyc(4'hF, 1'b1, 1'b0, 1'b0);
      repeat (8) cyc('0, 1'b0, 1'b0, 1'b1);
      repeat (6) cyc('0, 1'b0, 1'b1, 1'b0);

      // R5 fill the whole pool, then stall; R9 all buffers distinct
      repeat (40) cyc(4'b0101, 1'b0, 1'b0, 1'b0);
      cyc('0, 1'b1, 1'b0, 1'b0);
      // R7 release and acquire in one cycle at the full boundary
      repeat (20) cyc(4'hF, 1'b1, 1'b1, 1'b0);
      repeat (30) cyc(4'hA, 1'b0, 1'b1, 1'b1);
      repeat (30) cyc(4'h3, 1'b1, 1'b1, 1'b1);
      // R7 dual release drain
      repeat (45) cyc('0, 1'b0, 1'b1, 1'b1);
      // R7 no index lost: exactly NB accepted again
      repeat (36) cyc(4'h8, 1'b0, 1'b0, 1'b0);
      chk(mq_m.size() == NB, "R7 refill count", 64'(mq_m.size()), 64'(NB));
      repeat (36) cyc('0, 1'b0, 1'b1, 1'b0);
      summary();
   end
endmodule